// File: doc/BRIEF.md
# Indivisible Read-Modify-Write Bus Sequencer

This block is a bus master that carries out one indivisible read-then-write transfer on an asynchronous external bus. Each state of the sequence lasts one cycle of the block clock, which runs at twice the bus rate, so every state is a half bus clock. An operation starts with a one-cycle pulse on `start_i`. The address, function code, transfer size, number of read sub-cycles, write flag and write data are taken in on that pulse. The block then runs one or more read sub-cycles (states S0 to S5, with wait states between S2 and S3) and hands each captured word out with a one-cycle valid pulse. If a write is requested, it then runs a turnaround of idle states and a write sub-cycle (states S6 to S11, with wait states between S10 and S11).

The slave ends each sub-cycle by raising either or both acknowledge inputs. These inputs, and the cache-inhibit input, pass through a two-stage synchronizer before the state machine uses them. A lock output is held high for the whole operation, so an outside arbiter cannot hand the bus to another master between the read and the write. Address, function code and size do not change while lock is high. The read/write line turns late and the write data drivers turn on later still, so the two halves never drive the data bus at the same time.

Top module: `rmw_seq`

## Requirements
- R1: Out of reset and while idle, `as_o`, `ds_o`, `dben_o`, `data_oe_o`, `lock_o` and `done_o` are low and `rnw_o` is high.
- R2: In each read sub-cycle the first state drives address only; `as_o` and `ds_o` rise together in the next cycle and `dben_o` one cycle after that. `dben_o` is never high unless `as_o` and `ds_o` are both high.
- R3: `ack_i` bit 0 and bit 1 each end a sub-cycle alone or together. After the two-stage synchronizer, an acknowledge first driven high during the n-th cycle of `ds_o` in a read keeps `as_o` high for exactly n+4 cycles, and in a write for exactly n+3 cycles.
- R4: While the synchronized acknowledge inputs are both low in a wait state, the block stays in that wait state with strobes held, however long that lasts.
- R5: Read data on `data_i` is captured at the end of state S4 and shown on `rd_data_o` with `rd_valid_o` high for exactly one cycle, in which `as_o` is already low. `cinh_o` carries the synchronized `cinh_i` taken at the start of S4.
- R6: `as_o`, `ds_o` and `dben_o` all go low in the same cycle at the end of every sub-cycle.
- R7: The read sub-cycle repeats `rd_count_i` times; a count of 0 runs one read. Each read sub-cycle lasts 7 + w cycles, where w is the number of wait states beyond the first.
- R8: While `lock_o` is high, `addr_o`, `fc_o` and `size_o` hold the values taken on the start pulse, and a `start_i` pulse has no effect.
- R9: With `write_i` low at start, `lock_o` falls right after the last read's S5, with no write states.
- R10: Before the write, `as_o` stays low for exactly 3 cycles after the last read. `rnw_o` stays high through the first of the two idle states and goes low in the second, while all strobes are low. `data_oe_o` first rises together with `as_o` in S8 and is never high while `rnw_o` is high.
- R11: During the write, `data_o` carries the write data taken at start while `data_oe_o` is high. The write sub-cycle lasts 7 + w cycles from S6 through S11.
- R12: `lock_o` is high from the first S0 through the final state of the operation, and `done_o` is high for exactly one cycle, the final one.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per half bus clock state |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an operation (ignored when busy) |
| addr_i | input | AW | Operand address for the operation |
| fc_i | input | 3 | Function code for the operation |
| size_i | input | 2 | Transfer size code driven on `size_o` |
| rd_count_i | input | CW | Number of read sub-cycles (0 treated as 1) |
| write_i | input | 1 | Run the write half after the reads |
| wdata_i | input | DW | Data to write |
| ack_i | input | 2 | Asynchronous acknowledge inputs, active high |
| cinh_i | input | 1 | Asynchronous cache-inhibit input, active high |
| data_i | input | DW | Read data from the bus |
| addr_o | output | AW | Bus address |
| fc_o | output | 3 | Bus function code |
| size_o | output | 2 | Bus transfer size |
| as_o | output | 1 | Address strobe, active high |
| ds_o | output | 1 | Data strobe, active high |
| dben_o | output | 1 | Data buffer enable, active high |
| rnw_o | output | 1 | Direction: 1 read, 0 write |
| data_oe_o | output | 1 | Output enable for the write data drivers |
| data_o | output | DW | Write data for the bus |
| lock_o | output | 1 | Bus held for the whole operation |
| rd_data_o | output | DW | Last captured read word |
| rd_valid_o | output | 1 | One-cycle pulse when `rd_data_o` is new |
| cinh_o | output | 1 | Cache-inhibit sampled for that read |
| done_o | output | 1 | High in the final cycle of an operation |

## Verification
Random operations mix read counts 0 to 3, write and no-write, acknowledge latencies of 0 to 4 cycles and all three acknowledge bit patterns. These show that the strobe length follows the latency through the synchronizer and that either acknowledge bit alone ends a sub-cycle. Directed cases add a count of zero, which must behave like one; the largest count; and a 25-cycle acknowledge delay, which shows that wait states hold with no upper limit. A start pulse sent in the middle of every operation, while the address is compared every cycle, shows that a busy block ignores new requests. The lock length and the idle gap before the write tell a correct turnaround apart from one that skips or adds states.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_RW, ST_S3, ST_S4, ST_S5,
    ST_S6, ST_S7, ST_S8, ST_S9, ST_S10, ST_WW, ST_S11
  } st_e;

  typedef struct packed {
    logic as;
    logic ds;
    logic dben;
    logic rnw;
    logic oe;
  } ctl_t;

  // Bus control levels for each state
  function automatic ctl_t ctl_of(input st_e s);
    ctl_t c;
    c = '{as: 1'b0, ds: 1'b0, dben: 1'b0, rnw: 1'b1, oe: 1'b0};
    case (s)
      ST_S1: begin
        c.as = 1'b1; c.ds = 1'b1;
      end
      ST_S2, ST_RW, ST_S3, ST_S4: begin
        c.as = 1'b1; c.ds = 1'b1; c.dben = 1'b1;
      end
      ST_S7: c.rnw = 1'b0;
      ST_S8: begin
        c.rnw = 1'b0; c.as = 1'b1; c.oe = 1'b1;
      end
      ST_S9, ST_S10, ST_WW: begin
        c.rnw = 1'b0; c.as = 1'b1; c.ds = 1'b1; c.dben = 1'b1; c.oe = 1'b1;
      end
      ST_S11: begin
        c.rnw = 1'b0; c.oe = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

  // Either acknowledge line ends a sub-cycle
  function automatic logic ack_any(input logic [1:0] a);
    return |a;
  endfunction

  // Read sub-cycles to run for a requested count
  function automatic int unsigned read_total(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/rmw_sync.sv
module rmw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import rmw_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] rd_count_i,
  input  logic          write_i,
  input  logic          ack_ok_i,
  output st_e           state_o,
  output logic          take_op_o,
  output logic          grab_cinh_o,
  output logic          grab_data_o,
  output logic          done_o
);
  st_e           st, nx;
  logic [CW-1:0] left;
  logic          wr_q;
  logic          last_read;

  assign take_op_o   = (st == ST_IDLE) && start_i;
  assign last_read   = (left <= CW'(1));
  assign grab_cinh_o = (st == ST_S3);
  assign grab_data_o = (st == ST_S4);
  assign done_o      = (st == ST_S11) || ((st == ST_S5) && last_read && !wr_q);
  assign state_o     = st;

  always_comb begin
    nx = st;
    case (st)
      ST_IDLE: if (start_i) nx = ST_S0;
      ST_S0:   nx = ST_S1;
      ST_S1:   nx = ST_S2;
      ST_S2:   nx = ack_ok_i ? ST_S3 : ST_RW;
      ST_RW:   nx = ack_ok_i ? ST_S3 : ST_RW;
      ST_S3:   nx = ST_S4;
      ST_S4:   nx = ST_S5;
      ST_S5: begin
        if (!last_read) nx = ST_S0;
        else if (wr_q)  nx = ST_S6;
        else            nx = ST_IDLE;
      end
      ST_S6:   nx = ST_S7;
      ST_S7:   nx = ST_S8;
      ST_S8:   nx = ST_S9;
      ST_S9:   nx = ST_S10;
      ST_S10:  nx = ack_ok_i ? ST_S11 : ST_WW;
      ST_WW:   nx = ack_ok_i ? ST_S11 : ST_WW;
      ST_S11:  nx = ST_IDLE;
      default: nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      left <= '0;
      wr_q <= 1'b0;
    end else begin
      st <= nx;
      if (take_op_o) begin
        left <= CW'(read_total(32'(rd_count_i)));
        wr_q <= write_i;
      end else if (st == ST_S5 && !last_read) begin
        left <= left - CW'(1);
      end
    end
  end
endmodule

// File: rtl/rmw_dp.sv
module rmw_dp #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    fc_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          grab_cinh_i,
  input  logic          grab_data_i,
  input  logic          cinh_s_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    fc_o,
  output logic [1:0]    size_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          cinh_o
);
  logic cinh_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      fc_o    <= '0;
      size_o  <= '0;
      wdata_o <= '0;
    end else if (take_op_i) begin
      addr_o  <= addr_i;
      fc_o    <= fc_i;
      size_o  <= size_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      cinh_pend  <= 1'b0;
      cinh_o     <= 1'b0;
    end else begin
      rd_valid_o <= grab_data_i;
      if (grab_cinh_i) cinh_pend <= cinh_s_i;
      if (grab_data_i) begin
        rd_data_o <= data_i;
        cinh_o    <= cinh_pend;
      end
    end
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    fc_i,
  input  logic [1:0]    size_i,
  input  logic [CW-1:0] rd_count_i,
  input  logic          write_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    ack_i,
  input  logic          cinh_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    fc_o,
  output logic [1:0]    size_o,
  output logic          as_o,
  output logic          ds_o,
  output logic          dben_o,
  output logic          rnw_o,
  output logic          data_oe_o,
  output logic [DW-1:0] data_o,
  output logic          lock_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          cinh_o,
  output logic          done_o
);
  logic [2:0] sync_q;
  logic       ack_ok;
  logic       in_wait;
  logic       take_op, grab_cinh, grab_data;
  st_e        state;
  ctl_t       ctl;

  rmw_sync #(.W(3), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cinh_i, ack_i}), .q_o(sync_q)
  );

  assign ack_ok = ack_any(sync_q[1:0]);

  rmw_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_count_i(rd_count_i),
    .write_i(write_i), .ack_ok_i(ack_ok), .state_o(state),
    .take_op_o(take_op), .grab_cinh_o(grab_cinh), .grab_data_o(grab_data),
    .done_o(done_o)
  );

  rmw_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .take_op_i(take_op), .addr_i(addr_i),
    .fc_i(fc_i), .size_i(size_i), .wdata_i(wdata_i),
    .grab_cinh_i(grab_cinh), .grab_data_i(grab_data), .cinh_s_i(sync_q[2]),
    .data_i(data_i), .addr_o(addr_o), .fc_o(fc_o), .size_o(size_o),
    .wdata_o(data_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .cinh_o(cinh_o)
  );

  assign ctl       = ctl_of(state);
  assign as_o      = ctl.as;
  assign ds_o      = ctl.ds;
  assign dben_o    = ctl.dben;
  assign rnw_o     = ctl.rnw;
  assign data_oe_o = ctl.oe;
  assign lock_o    = (state != ST_IDLE);
  assign in_wait   = (state == ST_RW) || (state == ST_WW);
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          as_o,
  input logic          ds_o,
  input logic          dben_o,
  input logic          rnw_o,
  input logic          data_oe_o,
  input logic          lock_o,
  input logic          rd_valid_o,
  input logic          ack_ok,
  input logic          in_wait,
  input logic [AW-1:0] addr_o,
  input logic [2:0]    fc_o,
  input logic [1:0]    size_o
);
  p_dben_needs_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dben_o |-> (as_o && ds_o));

  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !ack_ok) |=> (in_wait && as_o));

  p_valid_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (!as_o && $past(as_o)));

  p_strobes_drop_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_o) |-> (!ds_o && !dben_o));

  p_addr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && $past(lock_o)) |-> ($stable(addr_o) && $stable(fc_o) && $stable(size_o)));

  p_dir_turns_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rnw_o) |-> (!as_o && !ds_o && !dben_o && !data_oe_o));

  p_oe_after_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> ($past(!rnw_o) && as_o));

  p_no_oe_when_reading_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> !rnw_o);

  p_lock_covers_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (as_o || data_oe_o || !rnw_o) |-> lock_o);
endmodule

bind rmw_seq rmw_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_o(as_o), .ds_o(ds_o), .dben_o(dben_o),
  .rnw_o(rnw_o), .data_oe_o(data_oe_o), .lock_o(lock_o),
  .rd_valid_o(rd_valid_o), .ack_ok(ack_ok), .in_wait(in_wait),
  .addr_o(addr_o), .fc_o(fc_o), .size_o(size_o)
);

// File: tb/rmw_seq_test.sv
module rmw_seq_test;
  localparam int  AW = 32;
  localparam int  DW = 32;
  localparam int  CW = 3;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [2:0]    fc_i = '0;
  logic [1:0]    size_i = '0;
  logic [CW-1:0] rd_count_i = '0;
  logic          write_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [1:0]    ack_i = '0;
  logic          cinh_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [AW-1:0] addr_o;
  logic [2:0]    fc_o;
  logic [1:0]    size_o;
  logic          as_o, ds_o, dben_o, rnw_o, data_oe_o, lock_o;
  logic [DW-1:0] data_o, rd_data_o;
  logic          rd_valid_o, cinh_o, done_o;

  rmw_seq #(.AW(AW), .DW(DW), .CW(CW)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  // Operation parameters seen by the slave and monitor
  int          lat = 0;
  logic [1:0]  ack_pat = 2'b01;
  logic [DW-1:0] word_base = '0;
  logic [AW-1:0] op_addr = '0;
  logic [2:0]  op_fc = '0;
  logic [1:0]  op_size = '0;
  logic        op_cinh = 1'b0;
  logic [DW-1:0] op_wdata = '0;

  // Monitor state
  int scnt = 0, as_len = 0, lock_len = 0, rd_seen = 0, gap = 0, done_cnt = 0;
  int held_bad = 0, oe_bad = 0;
  bit as_prev = 1'b0, rnw_prev = 1'b1, mon_on = 1'b0;
  logic [DW-1:0] wcap = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int k);
    return word_base ^ (DW'(k + 1) * DW'(32'h01030507));
  endfunction

  function automatic int sub_len(input int l);
    return 7 + l;
  endfunction

  function automatic int reads_of(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Slave model and monitor, both at the falling edge
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (rd_valid_o) begin
        check(rd_data_o == word_of(rd_seen), "R5 read data", 64'(rd_data_o),
              64'(word_of(rd_seen)));
        check(cinh_o == op_cinh, "R5 cache-inhibit", 64'(cinh_o), 64'(op_cinh));
        check(!as_o, "R5 valid after strobe", 64'(as_o), 64'd0);
        rd_seen++;
      end
      if (as_o) begin
        if (!as_prev && !rnw_o) check(gap == 3, "R10 idle gap", 64'(gap), 64'd3);
        as_len++;
        gap = 0;
      end else if (as_prev) begin
        check(!ds_o && !dben_o, "R6 strobes drop", 64'({ds_o, dben_o}), 64'd0);
        if (rnw_o) check(as_len == 5 + lat, "R3 read strobe length", 64'(as_len),
                         64'(5 + lat));
        else       check(as_len == 4 + lat, "R3 write strobe length", 64'(as_len),
                         64'(4 + lat));
        as_len = 0;
      end
      if (lock_o && !as_o) gap++;
      if (rnw_prev && !rnw_o)
        check(gap == 3 && !as_o, "R10 direction turn", 64'(gap), 64'd3);
      if (lock_o) lock_len++;
      if (done_o) done_cnt++;
      if (lock_o && (addr_o != op_addr || fc_o != op_fc || size_o != op_size)) held_bad++;
      if (data_oe_o && (rnw_o || data_o != op_wdata)) oe_bad++;
      // slave
      if (as_o && ds_o) begin
        scnt++;
        if (scnt > lat) ack_i = ack_pat;
        if (!rnw_o && ack_i != 2'b00) wcap = data_o;
      end else begin
        scnt = 0;
        ack_i = 2'b00;
      end
      data_i = word_of(rd_seen);
      as_prev = as_o;
      rnw_prev = rnw_o;
    end
  end

  task automatic run_op(input int n, input bit wr, input int l, input logic [1:0] pat);
    int tot;
    int exp_lock;
    @(negedge clk);
    lat = l; ack_pat = pat;
    word_base = DW'($urandom);
    op_addr = AW'($urandom); op_fc = 3'($urandom); op_size = 2'($urandom);
    op_cinh = 1'($urandom); op_wdata = DW'($urandom);
    rd_seen = 0; lock_len = 0; done_cnt = 0; held_bad = 0; oe_bad = 0;
    gap = 0; wcap = '0;
    addr_i = op_addr; fc_i = op_fc; size_i = op_size; cinh_i = op_cinh;
    wdata_i = op_wdata; rd_count_i = CW'(n); write_i = wr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    addr_i = ~op_addr; fc_i = ~op_fc; wdata_i = ~op_wdata;
    repeat (3) @(negedge clk);
    start_i = 1'b1;  // must be ignored while busy
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 2000 && lock_o; i++) @(negedge clk);
    tot = reads_of(n);
    exp_lock = tot * sub_len(l) + (wr ? sub_len(l) : 0);
    check(rd_seen == tot, "R7 read count", 64'(rd_seen), 64'(tot));
    if (wr) check(lock_len == exp_lock, "R11 lock length with write", 64'(lock_len),
                  64'(exp_lock));
    else    check(lock_len == exp_lock, "R9 lock length without write", 64'(lock_len),
                  64'(exp_lock));
    check(done_cnt == 1, "R12 done pulse", 64'(done_cnt), 64'd1);
    check(held_bad == 0, "R8 address held", 64'(held_bad), 64'd0);
    if (wr) begin
      check(wcap == op_wdata, "R11 write data", 64'(wcap), 64'(op_wdata));
      check(oe_bad == 0, "R10 output enable", 64'(oe_bad), 64'd0);
    end
    repeat (4) @(negedge clk);
    check(!lock_o && rnw_o, "R8 ignored start", 64'(lock_o), 64'd0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] pats [3];
    pats[0] = 2'b01; pats[1] = 2'b10; pats[2] = 2'b11;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!as_o && !ds_o && !dben_o && !data_oe_o && !lock_o && !done_o,
          "R1 reset strobes", 64'({as_o, ds_o, dben_o, data_oe_o, lock_o, done_o}), 64'd0);
    check(rnw_o, "R1 reset direction", 64'(rnw_o), 64'd1);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    check(!lock_o && !as_o && rnw_o, "R1 idle after reset", 64'({lock_o, as_o}), 64'd0);
    // R2: strobe order in the first read
    @(negedge clk);
    lat = 0; ack_pat = 2'b01;
    addr_i = 32'h1000; rd_count_i = CW'(1); write_i = 1'b0; start_i = 1'b1;
    op_addr = addr_i; op_fc = fc_i; op_size = size_i; op_cinh = cinh_i;
    rd_seen = 0; word_base = data_i ^ data_i;
    @(negedge clk);
    start_i = 1'b0;
    check(lock_o && !as_o && !ds_o, "R2 first state address only", 64'({as_o, ds_o}), 64'd0);
    @(negedge clk);
    check(as_o && ds_o && !dben_o, "R2 strobes before buffers", 64'({as_o, ds_o, dben_o}),
          64'b110);
    @(negedge clk);
    check(as_o && ds_o && dben_o, "R2 buffers enabled", 64'({as_o, ds_o, dben_o}), 64'b111);
    for (int i = 0; i < 20 && lock_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    // directed corners
    run_op(0, 1'b1, 0, 2'b01);   // R7 zero count behaves as one
    run_op(7, 1'b1, 1, 2'b10);   // R7 largest count
    run_op(2, 1'b1, 25, 2'b11);  // R4 long wait
    run_op(1, 1'b0, 0, 2'b10);   // R9 read only
    for (int k = 0; k < 30; k++)
      run_op($urandom_range(0, 3), 1'($urandom), $urandom_range(0, 4),
             pats[$urandom_range(0, 2)]);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule